// File: doc/BRIEF.md
# Load-Store Disambiguation Buffer

This block tracks every in-flight load and store in program order, from the cycle it issues until it retires. An entry is claimed at issue, often before its address is known. Addresses are supplied later, in any order, through a single resolve port. Store data is marked ready through a separate port. The block works speculatively: a load is assumed not to depend on any earlier store, and the dependence check runs only when an address resolves.

When a load's address resolves, the block searches the older stores that already have an address. If the youngest matching store has its data, that data is forwarded. If the data is not there yet, the load receives the station tag of that store instead. If no older store matches, the load may go to memory. When a store's address resolves, the block searches the younger loads that already resolved to the same address. If it finds one, it requests a flush. That load and every entry younger than it are dropped, and the allocation point moves back to the load's slot.

The buffer is a circular queue with a head (oldest) and a tail (next free slot). Retirement always removes the head. Addresses are compared as full word addresses.

Top module: `lsd_buffer`

## Requirements
- R1: After synchronous reset the buffer is empty: `alloc_ready` is 1, `alloc_idx` is 0, and `resp_valid` and `flush_valid` are 0.
- R2: Allocation hands out slots in program order. `alloc_idx` names the slot the next allocation takes, and it advances by one modulo DEPTH on each accepted allocation. `retire_valid` frees the oldest entry and is ignored when the buffer is empty.
- R3: With DEPTH entries outstanding, `alloc_ready` is 0 and a requested allocation is ignored, so `alloc_idx` does not move.
- R4: One cycle after a load resolves, `resp_valid` is 1 and `resp_idx` is the load's slot. If no older resolved store has the same address, `resp_kind` is 0 (memory access granted).
- R5: If the selected older store has its data ready, `resp_kind` is 1 and `resp_data` carries that store's data.
- R6: If the selected older store's data is not ready, `resp_kind` is 2 and `resp_tag` carries that store's station tag.
- R7: When several older resolved stores match, the youngest of them is selected.
- R8: A load's search ignores younger stores, stores whose address has not resolved, and stores with a different address.
- R9: One cycle after a store resolves, `flush_valid` is 1 if a younger load with the same address has already resolved. `flush_idx` is the oldest such load; loads that have not yet resolved are not considered.
- R10: A flush drops the flagged load and every younger entry. The next allocation reuses the flagged slot, the count shrinks to match, and `alloc_ready` is 0 in the cycle the flush is detected.
- R11: A store resolve that finds no conflicting load produces neither a response nor a flush, and a single resolve never produces both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate a new entry at the tail |
| alloc_is_store | input | 1 | 1 for a store, 0 for a load |
| alloc_tag | input | TAG_W | Reservation-station tag of the allocated operation |
| alloc_ready | output | 1 | An allocation this cycle is accepted |
| alloc_idx | output | IDX_W | Slot the next allocation will occupy |
| res_valid | input | 1 | An address is being resolved |
| res_idx | input | IDX_W | Slot whose address resolves |
| res_addr | input | ADDR_W | Resolved word address |
| sdata_valid | input | 1 | Store data becomes ready |
| sdata_idx | input | IDX_W | Slot of the store whose data arrives |
| sdata_value | input | DATA_W | Store data |
| retire_valid | input | 1 | Retire the oldest entry |
| resp_valid | output | 1 | Load resolve result is valid |
| resp_kind | output | 2 | 0 memory, 1 forward, 2 wait on tag |
| resp_idx | output | IDX_W | Slot of the load the result belongs to |
| resp_data | output | DATA_W | Forwarded data (kind 1) |
| resp_tag | output | TAG_W | Tag of the selected store (kinds 1 and 2) |
| flush_valid | output | 1 | Misspeculated load detected |
| flush_idx | output | IDX_W | Slot of the oldest misspeculated load |

## Verification
Directed patterns put a load behind two matching stores, one with data and one without, plus a younger matching store. This separates picking the youngest older store from picking the oldest one or searching in the wrong direction, and it separates the forward outcome from the wait outcome. Another pattern resolves a store after its younger loads, with an unresolved load sitting between them. It shows whether the flush picks the oldest resolved load and skips unresolved ones, and whether the tail rewinds to the right slot. A long random run over a four-address pool mixes allocation, resolution in scrambled order, data arrival, retirement at empty and full, and slot wraparound. Each cycle it is compared with a bench reference model, which exposes wrong age arithmetic across the wrap and wrong handling of operations that land in the same cycle.

// File: rtl/lsd_pkg.sv
`timescale 1ns/1ps
package lsd_pkg;

    // Outcome reported for a resolved load.
    typedef enum logic [1:0] {
        RESP_MEM  = 2'd0,
        RESP_FWD  = 2'd1,
        RESP_WAIT = 2'd2
    } resp_kind_e;

    localparam int LSD_DEPTH_DEF = 8;
    localparam int LSD_ADDR_DEF  = 32;
    localparam int LSD_DATA_DEF  = 32;
    localparam int LSD_TAG_DEF   = 6;

endpackage

// File: rtl/lsd_match_vec.sv
`timescale 1ns/1ps
// Per-slot address comparison, split into store and load candidate masks.
module lsd_match_vec #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 32
) (
    input  logic [DEPTH-1:0]        valid,
    input  logic [DEPTH-1:0]        is_store,
    input  logic [DEPTH-1:0]        known,
    input  logic [DEPTH*ADDR_W-1:0] addr_flat,
    input  logic [ADDR_W-1:0]       key,
    output logic [DEPTH-1:0]        store_hit,
    output logic [DEPTH-1:0]        load_hit
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic eq;
        assign eq           = (addr_flat[i*ADDR_W +: ADDR_W] == key);
        assign store_hit[i] = valid[i] &  is_store[i] & known[i] & eq;
        assign load_hit[i]  = valid[i] & ~is_store[i] & known[i] & eq;
    end
endmodule

// File: rtl/lsd_age_pick.sv
`timescale 1ns/1ps
// Age-ordered selection relative to a reference slot.
// SEEK_OLDER=1: youngest candidate strictly older than the reference.
// SEEK_OLDER=0: oldest candidate strictly younger than the reference.
module lsd_age_pick #(
    parameter int DEPTH      = 8,
    parameter bit SEEK_OLDER = 1'b1,
    localparam int IDX_W     = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] head,
    input  logic [IDX_W-1:0] ref_idx,
    input  logic [DEPTH-1:0] cand,
    output logic             hit,
    output logic [IDX_W-1:0] pick
);
    logic [IDX_W-1:0] ref_age;
    assign ref_age = ref_idx - head;

    if (SEEK_OLDER) begin : g_older
        always_comb begin
            hit  = 1'b0;
            pick = '0;
            for (int k = 0; k < DEPTH; k++) begin
                if (k < int'(ref_age) && cand[head + IDX_W'(k)]) begin
                    hit  = 1'b1;
                    pick = head + IDX_W'(k);
                end
            end
        end
    end else begin : g_younger
        always_comb begin
            hit  = 1'b0;
            pick = '0;
            for (int k = DEPTH - 1; k >= 0; k--) begin
                if (k > int'(ref_age) && cand[head + IDX_W'(k)]) begin
                    hit  = 1'b1;
                    pick = head + IDX_W'(k);
                end
            end
        end
    end
endmodule

// File: rtl/lsd_buffer.sv
`timescale 1ns/1ps
module lsd_buffer
    import lsd_pkg::*;
#(
    parameter int DEPTH  = LSD_DEPTH_DEF,
    parameter int ADDR_W = LSD_ADDR_DEF,
    parameter int DATA_W = LSD_DATA_DEF,
    parameter int TAG_W  = LSD_TAG_DEF,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic              alloc_is_store,
    input  logic [TAG_W-1:0]  alloc_tag,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              res_valid,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic [ADDR_W-1:0] res_addr,
    input  logic              sdata_valid,
    input  logic [IDX_W-1:0]  sdata_idx,
    input  logic [DATA_W-1:0] sdata_value,
    input  logic              retire_valid,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic [IDX_W-1:0]  resp_idx,
    output logic [DATA_W-1:0] resp_data,
    output logic [TAG_W-1:0]  resp_tag,
    output logic              flush_valid,
    output logic [IDX_W-1:0]  flush_idx
);
    typedef struct packed {
        logic              valid;
        logic              is_store;
        logic              known;
        logic              rdy;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
    } slot_t;

    slot_t            ent [DEPTH];
    logic [IDX_W-1:0] head, tail;
    logic [CNT_W-1:0] count, cnt_next;

    // Flattened views for the comparators.
    logic [DEPTH-1:0]        v_vec, st_vec, kn_vec, squash;
    logic [DEPTH*ADDR_W-1:0] addr_flat;
    logic [DEPTH-1:0]        st_cand, ld_cand;

    logic             old_hit, yng_hit;
    logic [IDX_W-1:0] old_pick, yng_pick, flush_age;
    logic             res_is_store, load_go, flush_now, alloc_fire, retire_fire;

    for (genvar i = 0; i < DEPTH; i++) begin : g_flat
        logic [IDX_W-1:0] age_i;
        assign v_vec[i]                       = ent[i].valid;
        assign st_vec[i]                      = ent[i].is_store;
        assign kn_vec[i]                      = ent[i].known;
        assign addr_flat[i*ADDR_W +: ADDR_W]  = ent[i].addr;
        assign age_i                          = IDX_W'(i) - head;
        assign squash[i]                      = flush_now && (age_i >= flush_age);
    end

    lsd_match_vec #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_match (
        .valid(v_vec), .is_store(st_vec), .known(kn_vec),
        .addr_flat(addr_flat), .key(res_addr),
        .store_hit(st_cand), .load_hit(ld_cand)
    );

    lsd_age_pick #(.DEPTH(DEPTH), .SEEK_OLDER(1'b1)) u_pick_older (
        .head(head), .ref_idx(res_idx), .cand(st_cand),
        .hit(old_hit), .pick(old_pick)
    );

    lsd_age_pick #(.DEPTH(DEPTH), .SEEK_OLDER(1'b0)) u_pick_younger (
        .head(head), .ref_idx(res_idx), .cand(ld_cand),
        .hit(yng_hit), .pick(yng_pick)
    );

    assign res_is_store = ent[res_idx].is_store;
    assign load_go      = res_valid && !res_is_store;
    assign flush_now    = res_valid && res_is_store && yng_hit;
    assign flush_age    = yng_pick - head;
    assign alloc_ready  = (count != CNT_W'(DEPTH)) && !flush_now;
    assign alloc_fire   = alloc_valid && alloc_ready;
    assign retire_fire  = retire_valid && (count != '0);
    assign alloc_idx    = tail;

    always_comb begin
        cnt_next = flush_now ? CNT_W'(flush_age) : count;
        cnt_next = cnt_next - CNT_W'(retire_fire) + CNT_W'(alloc_fire);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
            head        <= '0;
            tail        <= '0;
            count       <= '0;
            resp_valid  <= 1'b0;
            resp_kind   <= RESP_MEM;
            resp_idx    <= '0;
            resp_data   <= '0;
            resp_tag    <= '0;
            flush_valid <= 1'b0;
            flush_idx   <= '0;
        end else begin
            resp_valid  <= load_go;
            resp_idx    <= res_idx;
            if (load_go && old_hit) begin
                resp_kind <= ent[old_pick].rdy ? RESP_FWD : RESP_WAIT;
                resp_data <= ent[old_pick].rdy ? ent[old_pick].data : '0;
                resp_tag  <= ent[old_pick].tag;
            end else begin
                resp_kind <= RESP_MEM;
                resp_data <= '0;
                resp_tag  <= '0;
            end
            flush_valid <= flush_now;
            flush_idx   <= yng_pick;

            if (res_valid) begin
                ent[res_idx].known <= 1'b1;
                ent[res_idx].addr  <= res_addr;
            end
            if (sdata_valid) begin
                ent[sdata_idx].rdy  <= 1'b1;
                ent[sdata_idx].data <= sdata_value;
            end
            if (alloc_fire) begin
                ent[tail] <= '{valid: 1'b1, is_store: alloc_is_store, known: 1'b0,
                               rdy: 1'b0, addr: '0, data: '0, tag: alloc_tag};
            end
            if (retire_fire) begin
                ent[head].valid <= 1'b0;
                head            <= head + 1'b1;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (squash[i]) ent[i].valid <= 1'b0;
            end
            if (flush_now)       tail <= yng_pick;
            else if (alloc_fire) tail <= tail + 1'b1;
            count <= cnt_next;
        end
    end
endmodule

// File: rtl/lsd_buffer_chk.sv
`timescale 1ns/1ps
module lsd_buffer_chk #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_ready,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             res_valid,
    input logic             resp_valid,
    input logic             flush_valid,
    input logic [IDX_W-1:0] flush_idx,
    input logic [CNT_W-1:0] count
);
    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!resp_valid && !flush_valid && alloc_ready && alloc_idx == '0));

    // R2
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R3
    full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH)) |-> !alloc_ready);

    // R4
    resp_follows_resolve_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(res_valid));

    // R9
    flush_follows_resolve_chk: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> $past(res_valid));

    // R10
    flush_rewinds_tail_chk: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> (alloc_idx == flush_idx));

    // R11
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        !(flush_valid && resp_valid));
endmodule

bind lsd_buffer lsd_buffer_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_lsd_chk (
    .clk(clk), .rst(rst), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .res_valid(res_valid), .resp_valid(resp_valid), .flush_valid(flush_valid),
    .flush_idx(flush_idx), .count(count)
);

// File: tb/test_lsd_buffer.sv
`timescale 1ns/1ps
module test_lsd_buffer;
    localparam int DEPTH  = 8;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int TAG_W  = 6;
    localparam int IDX_W  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_v = 0, a_st = 0, r_v = 0, d_v = 0, ret_v = 0;
    logic [TAG_W-1:0]  a_tag = '0;
    logic [IDX_W-1:0]  r_idx = '0, d_idx = '0;
    logic [ADDR_W-1:0] r_addr = '0;
    logic [DATA_W-1:0] d_val = '0;

    logic              alloc_ready, resp_valid, flush_valid;
    logic [IDX_W-1:0]  alloc_idx, resp_idx, flush_idx;
    logic [1:0]        resp_kind;
    logic [DATA_W-1:0] resp_data;
    logic [TAG_W-1:0]  resp_tag;

    always #2.5 clk = ~clk;

    lsd_buffer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_lsd_buffer (
        .clk(clk), .rst(rst),
        .alloc_valid(a_v), .alloc_is_store(a_st), .alloc_tag(a_tag),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .res_valid(r_v), .res_idx(r_idx), .res_addr(r_addr),
        .sdata_valid(d_v), .sdata_idx(d_idx), .sdata_value(d_val),
        .retire_valid(ret_v),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_idx(resp_idx),
        .resp_data(resp_data), .resp_tag(resp_tag),
        .flush_valid(flush_valid), .flush_idx(flush_idx)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;

    // Reference model state
    bit              mv[DEPTH], ms[DEPTH], mk[DEPTH], mr[DEPTH];
    longint          ma[DEPTH], md[DEPTH], mt[DEPTH];
    int              mh = 0, mtl = 0, mc = 0;

    task automatic check(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: inputs already driven after a falling edge.
    task automatic run_cycle();
        bit  e_flush = 0, e_resp = 0, found = 0, e_ready, afire, rfire;
        int  e_fidx = 0, e_kind = 0, ra, oh, fa;
        longint e_data = 0, e_tag = 0;
        string kreq;
        ra = (int'(r_idx) - mh) & (DEPTH - 1);
        if (r_v) begin
            if (ms[r_idx]) begin
                for (int k = ra + 1; k < DEPTH; k++) begin
                    int j = (mh + k) % DEPTH;
                    if (!e_flush && mv[j] && !ms[j] && mk[j] && ma[j] == longint'(r_addr)) begin
                        e_flush = 1; e_fidx = j;
                    end
                end
            end else begin
                e_resp = 1;
                for (int k = ra - 1; k >= 0; k--) begin
                    int j = (mh + k) % DEPTH;
                    if (!found && mv[j] && ms[j] && mk[j] && ma[j] == longint'(r_addr)) begin
                        found  = 1;
                        e_kind = mr[j] ? 1 : 2;
                        e_data = mr[j] ? md[j] : 0;
                        e_tag  = mt[j];
                    end
                end
            end
        end
        e_ready = (mc < DEPTH) && !e_flush;
        #1;
        check("R3", "alloc_ready", alloc_ready, e_ready);
        check("R2", "alloc_idx", alloc_idx, mtl);
        @(posedge clk);
        #1;
        kreq = (e_kind == 0) ? "R4" : (e_kind == 1) ? "R5" : "R6";
        check("R4", "resp_valid", resp_valid, e_resp);
        check("R9", "flush_valid", flush_valid, e_flush);
        if (e_resp) begin
            check("R4", "resp_idx", resp_idx, r_idx);
            check(kreq, "resp_kind", resp_kind, e_kind);
            if (e_kind == 1) check("R5", "resp_data", resp_data, e_data);
            if (e_kind != 0) check("R6", "resp_tag", resp_tag, e_tag);
        end
        if (e_flush) check("R9", "flush_idx", flush_idx, e_fidx);
        // model update, same ordering as the requirements
        oh = mh;
        afire = a_v && e_ready;
        rfire = ret_v && (mc > 0);
        if (r_v) begin mk[r_idx] = 1; ma[r_idx] = r_addr; end
        if (d_v) begin mr[d_idx] = 1; md[d_idx] = d_val; end
        if (afire) begin
            mv[mtl] = 1; ms[mtl] = a_st; mk[mtl] = 0; mr[mtl] = 0; mt[mtl] = a_tag;
            mtl = (mtl + 1) % DEPTH;
        end
        if (rfire) begin mv[oh] = 0; mh = (oh + 1) % DEPTH; end
        if (e_flush) begin
            fa = (e_fidx - oh) & (DEPTH - 1);
            for (int i = 0; i < DEPTH; i++)
                if (((i - oh) & (DEPTH - 1)) >= fa) mv[i] = 0;
            mtl = e_fidx;
            mc = fa;
        end
        mc = mc - int'(rfire) + int'(afire);
        @(negedge clk);
        a_v = 0; r_v = 0; d_v = 0; ret_v = 0;
    endtask

    task automatic alloc_op(input bit st, input int tag);
        a_v = 1; a_st = st; a_tag = TAG_W'(tag); run_cycle();
    endtask
    task automatic res_op(input int idx, input longint addr);
        r_v = 1; r_idx = IDX_W'(idx); r_addr = ADDR_W'(addr); run_cycle();
    endtask
    task automatic data_op(input int idx, input longint val);
        d_v = 1; d_idx = IDX_W'(idx); d_val = DATA_W'(val); run_cycle();
    endtask
    task automatic retire_op();
        ret_v = 1; run_cycle();
    endtask

    initial begin
        #1000000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) begin
            mv[i] = 0; ms[i] = 0; mk[i] = 0; mr[i] = 0; ma[i] = 0; md[i] = 0; mt[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "alloc_ready", alloc_ready, 1);
        check("R1", "alloc_idx", alloc_idx, 0);
        check("R1", "resp_valid", resp_valid, 0);
        check("R1", "flush_valid", flush_valid, 0);
        @(negedge clk);
        rst = 0;

        // Scenario A: forwarding, waiting, youngest selection
        alloc_op(1, 5);  // slot0 store
        alloc_op(1, 6);  // slot1 store
        alloc_op(0, 0);  // slot2 load
        alloc_op(0, 0);  // slot3 load
        alloc_op(1, 9);  // slot4 store
        res_op(0, 'h100);
        check("R11", "store resolve no flush", flush_valid, 0);
        check("R11", "store resolve no resp", resp_valid, 0);
        data_op(0, 'hAAAA);
        res_op(1, 'h100);
        res_op(4, 'h100);
        res_op(2, 'h100);
        check("R7", "youngest older store picked kind", resp_kind, 2);
        check("R7", "youngest older store tag", resp_tag, 6);
        check("R8", "younger store ignored tag", resp_tag != 9, 1);
        data_op(1, 'hBBBB);
        res_op(3, 'h100);
        check("R5", "forward kind", resp_kind, 1);
        check("R5", "forward data", resp_data, 'hBBBB);
        alloc_op(0, 0);  // slot5 load
        alloc_op(1, 12); // slot6 store
        alloc_op(0, 0);  // slot7 load
        check("R3", "full ready low", alloc_ready, 0);
        alloc_op(0, 0);  // ignored
        check("R3", "full alloc ignored idx", alloc_idx, 0);
        res_op(5, 'h104);
        check("R8", "different address goes to memory", resp_kind, 0);
        res_op(7, 'h300);
        check("R4", "no older match kind", resp_kind, 0);
        check("R4", "resp idx", resp_idx, 7);
        res_op(6, 'h300);
        check("R9", "flush raised", flush_valid, 1);
        check("R9", "flush idx", flush_idx, 7);
        check("R10", "tail rewound", alloc_idx, 7);
        check("R10", "room after flush", alloc_ready, 1);
        for (int i = 0; i < 7; i++) retire_op();
        retire_op();     // empty: ignored
        check("R2", "retire at empty keeps tail", alloc_idx, 7);

        // Scenario B: flush picks oldest resolved younger load across wrap
        alloc_op(1, 3);  // slot7 store
        check("R2", "wrap to slot0", alloc_idx, 0);
        alloc_op(0, 0);  // slot0 load, stays unresolved
        alloc_op(0, 0);  // slot1 load
        alloc_op(0, 0);  // slot2 load
        alloc_op(1, 4);  // slot3 store
        res_op(2, 'h700);
        res_op(1, 'h700);
        res_op(7, 'h700);
        check("R9", "oldest resolved younger load", flush_idx, 1);
        check("R10", "tail at flagged slot", alloc_idx, 1);
        for (int i = 0; i < 6; i++) alloc_op(0, 0);
        check("R10", "only two entries survived", alloc_ready, 0);
        for (int i = 0; i < 8; i++) retire_op();

        // Random phase
        for (int c = 0; c < 4000; c++) begin
            int st;
            a_v   = ($urandom % 2) == 0;
            a_st  = $urandom % 2;
            a_tag = TAG_W'($urandom);
            st = $urandom % DEPTH;
            if (($urandom % 5) < 2) begin
                for (int t = 0; t < DEPTH; t++) begin
                    int j = (st + t) % DEPTH;
                    if (!r_v && mv[j] && !mk[j]) begin
                        r_v = 1; r_idx = IDX_W'(j);
                        r_addr = ADDR_W'(32'h40 + ($urandom % 4));
                    end
                end
            end
            if (($urandom % 10) < 3) begin
                for (int t = 0; t < DEPTH; t++) begin
                    int j = (st + t) % DEPTH;
                    if (!d_v && mv[j] && ms[j] && !mr[j]) begin
                        d_v = 1; d_idx = IDX_W'(j); d_val = DATA_W'($urandom);
                    end
                end
            end
            ret_v = ($urandom % 4) == 0;
            run_cycle();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule